// File: doc/BRIEF.md
# Timer-Based Switch Debouncer

This block turns the chattering level from a mechanical switch into a clean single-bit level. The raw contact signal is asynchronous to the system clock, so it first passes through a short chain of flip-flops. The synchronized bit then feeds a two-state controller and a free-running timer.

The controller keeps one state bit, and that bit is the debounced output. While the synchronized input matches the output, the timer is held at zero. When the two disagree, the timer counts up. If the disagreement lasts until the counter rolls over, the registered carry-out of the incrementer tells the controller to flip its state. Any return of the input to the old level during that window clears the timer, and the window starts again.

With the default 18-bit counter and a 50 MHz clock, the window is 262,144 cycles, about 5.2 ms. A narrower counter gives a shorter window.

Top module: `switch_debouncer`

## Requirements
- R1: While `rst` is high at a clock edge, the output goes low after that edge and any partly elapsed window is discarded. After `rst` falls, timing starts again from the synchronized input.
- R2: When the raw input moves to a new level and stays there, the output takes that level exactly 2^CNT_W + 3 clock edges after the edge that follows the input change. Two of those edges are spent in the synchronizer and one in the registered carry.
- R3: If the synchronized input disagrees with the output for 2^CNT_W consecutive cycles or fewer, the output does not change. A disagreement of 2^CNT_W + 1 cycles is the shortest one that flips the output.
- R4: A single cycle in which the synchronized input returns to the output level restarts the window. The flip then happens 2^CNT_W + 3 edges after the last change of the raw input away from the output level. Once the output flips, the timer starts again from zero.
- R5: A falling transition (output high, input low) follows the same timing as a rising one.
- R6: The output changes only at an edge where the controller saw both the input disagreeing with the output and the timer expiry. While the input matches the output, the output holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset. It may be tied low, because the state converges once the input and output agree |
| sw_raw_i | input | 1 | Raw switch contact level, asynchronous to `clk` |
| sw_clean_o | output | 1 | Debounced level, equal to the controller state bit |

## Verification
The bench uses a 4-bit counter and goes after the exact window edge. A pulse of 2^CNT_W synchronized cycles must leave the output alone, while one cycle more must flip it. A design with an off-by-one in the carry path, or a carry that is not registered, would flip one edge early or late. A one-cycle bounce inside the window must restart the timing. A design that only paused the counter instead of clearing it would flip too soon. Rising and falling latencies are measured separately to catch a direction-dependent clear. Random bounce trains are compared cycle by cycle against a run-length model, which also exposes a timer that is not cleared after a flip when the input bounces straight back.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

    localparam int DEF_CNT_W       = 18;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;

    // Handshake between controller and timer.
    typedef struct packed {
        logic restart;   // controller -> timer: zero the count this cycle
        logic expired;   // timer -> controller: registered carry of the incrementer
    } tmr_link_t;

    function automatic level_e level_flip(input level_e l);
        return (l == LVL_LOW) ? LVL_HIGH : LVL_LOW;
    endfunction

    function automatic level_e level_of(input logic b);
        return b ? LVL_HIGH : LVL_LOW;
    endfunction

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
    parameter int STAGES = dbnc_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/dbnc_timer.sv
module dbnc_timer #(
    parameter int CNT_W = dbnc_pkg::DEF_CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic expired_o
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [SUM_W-1:0] inc;
    logic             exp_q;

    // Incrementer with carry out; the zero on restart comes from gating.
    assign inc   = {1'b0, cnt_q} + SUM_W'(1);
    assign cnt_d = inc[CNT_W-1:0] & {CNT_W{~restart_i}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            exp_q <= inc[CNT_W] & ~restart_i;
        end
    end

    assign expired_o = exp_q;
endmodule

// File: rtl/dbnc_ctrl.sv
module dbnc_ctrl
    import dbnc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sample_i,
    input  logic   expired_i,
    output logic   restart_o,
    output level_e level_o
);
    level_e st_q;
    level_e st_d;
    logic   match;
    logic   commit;

    assign match  = (level_of(sample_i) == st_q);
    assign commit = ~match & expired_i;

    // Restart the window on agreement, and also on the commit cycle, so the
    // next disagreement is timed from zero.
    assign restart_o = match | expired_i;

    always_comb begin
        st_d = st_q;
        if (commit) st_d = level_flip(st_q);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LVL_LOW;
        else     st_q <= st_d;
    end

    assign level_o = st_q;
endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer
    import dbnc_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_raw_i,
    output logic sw_clean_o
);
    logic      sync_bit;
    tmr_link_t link;
    level_e    state;

    dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (sw_raw_i),
        .sync_o  (sync_bit)
    );

    dbnc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sample_i  (sync_bit),
        .expired_i (link.expired),
        .restart_o (link.restart),
        .level_o   (state)
    );

    dbnc_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .restart_i (link.restart),
        .expired_o (link.expired)
    );

    assign sw_clean_o = (state == LVL_HIGH);
endmodule

// File: rtl/switch_debouncer_chk.sv
module switch_debouncer_chk (
    input logic clk,
    input logic rst,
    input logic sync_bit,
    input logic expired,
    input logic out
);
    AST_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out);                                                     // R1

    AST_FLIP_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (out != $past(out)) |-> ($past(expired) && ($past(sync_bit) != $past(out)))); // R6

    AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $past(sync_bit == out) |-> $stable(out));                                 // R3

    AST_EXPIRY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired);                                                    // R4

    AST_EXPIRY_AFTER_DISAGREE: assert property (@(posedge clk) disable iff (rst)
        expired |-> $past(sync_bit != out));                                      // R3
endmodule

bind switch_debouncer switch_debouncer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_bit (sync_bit),
    .expired  (link.expired),
    .out      (sw_clean_o)
);

// File: tb/sim_switch_debouncer.sv
module sim_switch_debouncer;
    localparam int W       = 4;
    localparam int THR     = (1 << W) + 1;   // synchronized disagreement cycles to flip
    localparam int LAT     = THR + 2;        // edges from raw change to output change
    localparam int CLK_PER = 10;
    localparam int WD_MAX  = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw = 1'b0;
    logic out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state
    logic m_s1 = 1'b0;
    logic m_s2 = 1'b0;
    logic m_exp = 1'b0;
    int   m_run = 0;
    bit   model_on = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    switch_debouncer #(.CNT_W(W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .sw_raw_i   (raw),
        .sw_clean_o (out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Model from the requirements: 2-stage delay, run length of disagreement.
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_s1 = 1'b0; m_s2 = 1'b0; m_exp = 1'b0; m_run = 0;
        end else begin
            if (m_s2 != m_exp) begin
                m_run++;
                if (m_run == THR) begin
                    m_exp = ~m_exp;
                    m_run = 0;
                end
            end else begin
                m_run = 0;
            end
            m_s2 = m_s1;
            m_s1 = raw;
        end
        if (cycles > WD_MAX) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_MAX);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst)
            check(out == m_exp, "R2/R3/R4/R5 model", int'(out), int'(m_exp));
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive raw at a negedge, return edges until out reaches target.
    task automatic measure(input logic lvl, output int n);
        raw = lvl;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (out == lvl) break;
        end
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));

        @(negedge clk);
        cyc(3);
        check(out == 1'b0, "R1 reset state", int'(out), 0);
        rst = 1'b0;
        model_on = 1'b1;
        cyc(5);

        // R2 rising latency
        measure(1'b1, n);
        check(n == LAT, "R2 rising latency", n, LAT);
        cyc(5);

        // R5 falling latency
        measure(1'b0, n);
        check(n == LAT, "R5 falling latency", n, LAT);
        cyc(5);

        // R3 pulse just too short
        raw = 1'b1; cyc(THR - 1); raw = 1'b0; cyc(THR + 8);
        check(out == 1'b0, "R3 short pulse ignored", int'(out), 0);

        // R3 shortest pulse that flips
        raw = 1'b1; cyc(THR); raw = 1'b0; cyc(4);
        check(out == 1'b1, "R3 threshold pulse flips", int'(out), 1);
        cyc(THR + 8);
        check(out == 1'b0, "R5 returns low", int'(out), 0);

        // R4 bounce restarts window
        raw = 1'b1; cyc(10); raw = 1'b0; cyc(1);
        measure(1'b1, n);
        check(n == LAT, "R4 restart after bounce", n, LAT);
        // R4 bounce straight back after flip times from zero
        raw = 1'b0; cyc(THR - 1); raw = 1'b1; cyc(6);
        check(out == 1'b1, "R4 post-flip short bounce ignored", int'(out), 1);
        measure(1'b0, n);
        check(n == LAT, "R5 falling after bounce", n, LAT);
        cyc(5);

        // R1 reset mid-window
        raw = 1'b1; cyc(10);
        rst = 1'b1; cyc(1);
        check(out == 1'b0, "R1 reset during window", int'(out), 0);
        cyc(1);
        rst = 1'b0;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); n++; @(negedge clk);
            if (out) break;
        end
        check(n == LAT, "R1 fresh window after reset", n, LAT);
        cyc(5);

        // R6 stable matching input never flips
        cyc(3 * THR);
        check(out == 1'b1, "R6 hold while matching", int'(out), 1);

        // Random bounce trains against the model
        for (int s = 0; s < 300; s++) begin
            int len;
            if ($urandom_range(0, 3) == 0) len = THR + int'($urandom_range(0, 6));
            else                           len = int'($urandom_range(1, THR));
            raw = ~raw;
            cyc(len);
        end
        cyc(LAT + 4);

        finish_run();
    end
endmodule